// File: doc/BRIEF.md
# Paged Program Counter

This block keeps the program counter for an 8K-word instruction space. It has a 13-bit PC and an 8-bit page latch. Software can read and write the low byte of the PC. The upper PC bits cannot be read. They are loaded only from the page latch when a load event happens.

Each cycle the PC does one of five things:
- it steps forward by one;
- it takes a new low byte from a data write;
- it jumps to an 11-bit immediate that stays inside the current 2K-word page;
- it reloads all 13 bits from a return address;
- it holds.

The upper bits come from the latch. Which latch bits are used depends on the event. A low-byte write uses five latch bits. A jump or call uses two. A computed jump is a low-byte write of an already-offset value. No carry from that write reaches the upper bits, so a table walk wraps inside its 256-word block. Instruction decode, the ALU and the return stack are outside this block.

Top module: `pc_pager`

## Requirements
- R1: While `rst_n` is low, `pc` and `lat_q` are zero, and both stay zero at the first edge after release when no event is requested.
- R2: When `inc_en` is the highest-priority request, `pc` becomes `pc+1` at the next edge. The value 0x1FFF wraps to 0x0000.
- R3: When `lo_wr` is the highest-priority request, `pc` becomes {latch[4:0], `lo_wdata`}. No carry from the low byte enters bits 12:8.
- R4: When `jmp_en` is the highest-priority request, `pc` becomes {latch[4:3], `jmp_target`}.
- R5: When `ret_en` is high, `pc` becomes `ret_addr` at the next edge, and the latch keeps its value.
- R6: The priority of requests is `ret_en` first, then `jmp_en`, then `lo_wr`, then `inc_en`.
- R7: A `lat_wr` loads `lat_wdata` into the latch, and the new value is seen on `lat_q` after the edge. PC loads in that same cycle use the old latch value. Latch bits 7:5 never reach `pc`.
- R8: `pc_lo` always equals `pc[7:0]`.
- R9: With no PC request, `pc` holds its value, and a latch write alone does not change `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Step the PC by one |
| lo_wr | input | 1 | Write strobe for the low byte |
| lo_wdata | input | 8 | New low byte |
| lat_wr | input | 1 | Write strobe for the page latch |
| lat_wdata | input | 8 | New latch value |
| jmp_en | input | 1 | Jump or call request |
| jmp_target | input | 11 | In-page target of the jump or call |
| ret_en | input | 1 | Return-load request |
| ret_addr | input | 13 | Full return address |
| pc | output | 13 | Program counter |
| pc_lo | output | 8 | Readable low byte of the PC |
| lat_q | output | 8 | Readable page latch |

## Verification
The bench builds the block with its default widths: a 13-bit PC, an 8-bit low byte, an 11-bit jump field and an 8-bit latch. This makes both page boundaries reachable in a few cycles. A return load places the PC at 0x1FFF, so the wrap on increment is tested directly. Latch values with bits 7:5 set show that those bits are ignored. Low-byte writes that look like overflowed table offsets show that the upper bits come only from the latch.

// File: rtl/pc_pager.sv
module pc_pager #(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int JMP_W = 11,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             lo_wr,
  input  logic [LO_W-1:0]  lo_wdata,
  input  logic             lat_wr,
  input  logic [LAT_W-1:0] lat_wdata,
  input  logic             jmp_en,
  input  logic [JMP_W-1:0] jmp_target,
  input  logic             ret_en,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc,
  output logic [LO_W-1:0]  pc_lo,
  output logic [LAT_W-1:0] lat_q
);
  localparam int HI_W = PC_W - LO_W;
  localparam int PG_W = PC_W - JMP_W;

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LAT_W-1:0] lat;

  always_comb begin
    if (ret_en)      pc_d = ret_addr;
    else if (jmp_en) pc_d = {lat[HI_W-1 -: PG_W], jmp_target};
    else if (lo_wr)  pc_d = {lat[HI_W-1:0], lo_wdata};
    else if (inc_en) pc_d = pc_q + PC_W'(1);
    else             pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      lat  <= '0;
    end else begin
      pc_q <= pc_d;
      if (lat_wr) lat <= lat_wdata;
    end
  end

  assign pc    = pc_q;
  assign pc_lo = pc_q[LO_W-1:0];
  assign lat_q = lat;
endmodule

// File: rtl/pc_pager_chk.sv
module pc_pager_chk #(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int JMP_W = 11,
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc_en,
  input logic             lo_wr,
  input logic [LO_W-1:0]  lo_wdata,
  input logic             lat_wr,
  input logic [LAT_W-1:0] lat_wdata,
  input logic             jmp_en,
  input logic [JMP_W-1:0] jmp_target,
  input logic             ret_en,
  input logic [PC_W-1:0]  ret_addr,
  input logic [PC_W-1:0]  pc,
  input logic [LO_W-1:0]  pc_lo,
  input logic [LAT_W-1:0] lat_q
);
  localparam int HI_W = PC_W - LO_W;
  localparam int PG_W = PC_W - JMP_W;

  p_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |=> pc == $past(ret_addr));

  p_jmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_en && jmp_en) |=> pc == {$past(lat_q[HI_W-1 -: PG_W]), $past(jmp_target)});

  p_lowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_en && !jmp_en && lo_wr) |=> pc == {$past(lat_q[HI_W-1:0]), $past(lo_wdata)});

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_en && !jmp_en && !lo_wr && inc_en) |=> pc == $past(pc) + PC_W'(1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_en && !jmp_en && !lo_wr && !inc_en) |=> $stable(pc));

  p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> lat_q == $past(lat_wdata));

  p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_wr |=> $stable(lat_q));
endmodule

bind pc_pager pc_pager_chk #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .LAT_W(LAT_W)) u_chk (.*);

// File: tb/tb_pc_pager.sv
module tb_pc_pager;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 0, lo_wr = 0, lat_wr = 0, jmp_en = 0, ret_en = 0;
  logic [7:0]  lo_wdata = '0, lat_wdata = '0;
  logic [10:0] jmp_target = '0;
  logic [12:0] ret_addr = '0;
  logic [12:0] pc;
  logic [7:0]  pc_lo, lat_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_pager dut (.clk, .rst_n, .inc_en, .lo_wr, .lo_wdata, .lat_wr, .lat_wdata,
                .jmp_en, .jmp_target, .ret_en, .ret_addr, .pc, .pc_lo, .lat_q);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    inc_en = 0; lo_wr = 0; lat_wr = 0; jmp_en = 0; ret_en = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic set_lat(input logic [7:0] v);
    lat_wr = 1; lat_wdata = v; cyc();
  endtask

  task automatic set_pc(input logic [12:0] v);
    ret_en = 1; ret_addr = v; cyc();
  endtask

  task automatic t_reset();
    rst_n = 0; inc_en = 1; #3;
    chk("R1 pc in reset", pc, 13'h0);
    chk("R1 latch in reset", lat_q, 8'h0);
    @(posedge clk); #2;
    idle(); rst_n = 1;
    cyc();
    chk("R1 pc after release", pc, 13'h0);
    chk("R1 latch after release", lat_q, 8'h0);
  endtask

  task automatic t_inc();
    set_pc(13'h00FE);
    inc_en = 1; cyc();
    chk("R2 inc", pc, 13'h00FF);
    chk("R8 low byte", pc_lo, 8'hFF);
    inc_en = 1; cyc();
    chk("R2 inc across byte", pc, 13'h0100);
    chk("R8 low byte", pc_lo, 8'h00);
    set_pc(13'h1FFF);
    inc_en = 1; cyc();
    chk("R2 wrap", pc, 13'h0000);
  endtask

  task automatic t_lowr();
    set_lat(8'h01);
    lo_wr = 1; lo_wdata = 8'hFF; cyc();
    chk("R3 low write", pc, 13'h01FF);
    set_lat(8'h02);
    lo_wr = 1; lo_wdata = 8'h10; cyc();
    chk("R3 computed jump no carry", pc, 13'h0210);
    set_lat(8'hF3);
    lo_wr = 1; lo_wdata = 8'h34; cyc();
    chk("R3 latch 4:0 used", pc, 13'h1334);
  endtask

  task automatic t_jump();
    set_lat(8'h1F);
    jmp_en = 1; jmp_target = 11'h123; cyc();
    chk("R4 jump page 3", pc, 13'h1923);
    set_lat(8'hE8);
    jmp_en = 1; jmp_target = 11'h7FF; cyc();
    chk("R4 jump page 1, high latch bits ignored R7", pc, 13'h0FFF);
    set_lat(8'h07);
    jmp_en = 1; jmp_target = 11'h005; cyc();
    chk("R4 bits 2:0 of latch ignored", pc, 13'h0005);
  endtask

  task automatic t_ret();
    set_lat(8'h0A);
    ret_en = 1; ret_addr = 13'h1ABC; cyc();
    chk("R5 return pc", pc, 13'h1ABC);
    chk("R5 latch kept", lat_q, 8'h0A);
  endtask

  task automatic t_prio();
    set_lat(8'h08);
    ret_en = 1; jmp_en = 1; lo_wr = 1; inc_en = 1;
    ret_addr = 13'h0777; jmp_target = 11'h111; lo_wdata = 8'h22; cyc();
    chk("R6 return wins", pc, 13'h0777);
    jmp_en = 1; lo_wr = 1; inc_en = 1; cyc();
    chk("R6 jump over low write", pc, 13'h0911);
    lo_wr = 1; inc_en = 1; cyc();
    chk("R6 low write over inc", pc, 13'h0822);
  endtask

  task automatic t_latch();
    set_lat(8'h00);
    lat_wr = 1; lat_wdata = 8'h1F; lo_wr = 1; lo_wdata = 8'h55; cyc();
    chk("R7 old latch used", pc, 13'h0055);
    chk("R7 latch loaded", lat_q, 8'h1F);
    lo_wr = 1; lo_wdata = 8'h55; cyc();
    chk("R7 new latch used", pc, 13'h1F55);
  endtask

  task automatic t_hold();
    set_pc(13'h0ABC);
    cyc(); cyc();
    chk("R9 hold", pc, 13'h0ABC);
    lat_wr = 1; lat_wdata = 8'hFF; cyc();
    chk("R9 latch write alone", pc, 13'h0ABC);
    chk("R8 low byte", pc_lo, 8'hBC);
  endtask

  task automatic t_rereset();
    set_lat(8'h15);
    set_pc(13'h1234);
    rst_n = 0; #3;
    chk("R1 async reset pc", pc, 13'h0);
    chk("R1 async reset latch", lat_q, 8'h0);
    @(posedge clk); #2; rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_inc();
    t_lowr();
    t_jump();
    t_ret();
    t_prio();
    t_latch();
    t_hold();
    t_rereset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule